// File: doc/BRIEF.md
# Power-State Change Interrupt Unit

This block sits beside an embedded core. It turns activity on a group of power-management control bits, on a real-time-clock alarm flag and on several wake sources into one level-high interrupt and a set of readable status bits. Each control bit can raise the interrupt when it changes, in either direction. The alarm can raise it for as long as the flag stays high. A mask register selects which of these sources may interrupt at all.

Wake events are recorded twice, in a host-side status register and in a wake-side copy. The same event sets both copies, and each copy is cleared only by its own write-one-to-clear accesses. A synchronous host-domain software reset clears the host-side copy only.

The core reaches four byte registers over a simple synchronous write strobe with a 2-bit address. Read data is combinational from the address and reads have no side effects. The inputs are expected to be synchronous to `clk` already.

Top module: `pwr_event_irq`

## Requirements
- R1: After reset the mask (address 0), change flags (address 1), host status (address 2) and wake copy (address 3) all read 0x00, and `irq` is low.
- R2: Address 0 is a read/write mask. Bit 0 enables the alarm. Bits 1..5 enable the S1..S5 control bits. Bit 6 enables the power-button-mode bit and bit 7 enables the supply-off bit.
- R3: When mask bit 0 is 1 and `rtcAlarm` is high before a clock edge, `irq` is high after that edge. `irq` goes low after the first edge at which `rtcAlarm` is sampled low, unless another source is pending. The alarm is never latched.
- R4: `pwrCtl` bit k (bit 0 is S0, bits 1..5 are S1..S5, bit 6 is power-button mode, bit 7 is supply-off) latches change flag bit k at address 1 on the edge at which it differs from its value at the previous edge, for a rise or a fall, when its enable is on. `irq` rises one edge later.
- R5: The S0 change flag (bit 0) is enabled whenever any of mask bits 1..5 is 1. Otherwise it is disabled.
- R6: A change on a bit whose enable is off does not set its flag.
- R7: Writing 1 to a bit at address 1 clears that flag, and writing 0 leaves it unchanged. `irq` falls one edge after the last enabled flag is cleared.
- R8: `wakeEvt` pulses set host status bits as follows: bit 0 of `wakeEvt` sets RI1 (bit 0), bit 1 sets RI2 (bit 1), bit 2 sets RING (bit 3), bit 3 sets module IRQ (bit 6) and bit 4 sets the software event (bit 7). Bits 2, 4 and 5 of address 2 always read 0.
- R9: Writing 1 to a bit at address 2 clears it, and writing 0 has no effect.
- R10: The same events set the same bits at address 3. Addresses 2 and 3 are cleared only by writes to themselves.
- R11: `hostSwRst` high at an edge clears address 2 and leaves address 3 unchanged.
- R12: If an event or a change arrives at the same edge as a write-1 clear of the same bit, the bit ends up set.
- R13: `irq` is the registered OR of the enabled pending sources. Clearing a mask bit hides its flag from `irq` without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| hostSwRst | input | 1 | Synchronous host-domain software reset of the host status |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` |
| pwrCtl | input | 8 | Power-management control bits being watched |
| rtcAlarm | input | 1 | Alarm flag level |
| wakeEvt | input | 5 | One-cycle wake event pulses |
| irq | output | 1 | Registered level-high interrupt |

## Verification
The bench targets the falling edge of a control bit. A design that only detects rises would never flag it. It checks that the S0 bit is enabled only through the S1..S5 enables, so a design that gives S0 its own enable, or none, would flag or miss it wrongly. It clears one status copy and reads the other, which catches shared clear paths. It applies a clear and an event to the same bit in one cycle, where a design that gives the clear priority would lose the event. It also drops a mask bit while the flag is pending, to confirm that the flag survives while `irq` falls, and it toggles the alarm to show that the alarm is a level source and is never latched.

// File: rtl/pwr_event_pkg.sv
package pwr_event_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int EVT_W  = 5;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CHG  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOST = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_WAKE = 2'd3;

  // host status bit position for each wake event input
  localparam int POS_RI1  = 0;
  localparam int POS_RI2  = 1;
  localparam int POS_RING = 3;
  localparam int POS_MOD  = 6;
  localparam int POS_SW   = 7;

  typedef struct packed {
    logic              wrMask;
    logic              clrChg;
    logic              clrHost;
    logic              clrWake;
    logic [DATA_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/pwr_event_ctrl.sv
module pwr_event_ctrl
  import pwr_event_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output regStrobe_t    strobe,
  output logic [AW-1:0] rdSel
);
  always_comb begin
    strobe         = '0;
    strobe.data    = busWdata;
    strobe.wrMask  = busWe && (busAddr == ADDR_MASK);
    strobe.clrChg  = busWe && (busAddr == ADDR_CHG);
    strobe.clrHost = busWe && (busAddr == ADDR_HOST);
    strobe.clrWake = busWe && (busAddr == ADDR_WAKE);
  end

  assign rdSel = busAddr;

  // R2: a write reaches exactly one register, and only when the write strobe is high
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMask, strobe.clrChg, strobe.clrHost, strobe.clrWake})
    && (busWe || !(strobe.wrMask || strobe.clrChg || strobe.clrHost || strobe.clrWake)));
endmodule

// File: rtl/pwr_event_dp.sv
module pwr_event_dp
  import pwr_event_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int EW = EVT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostSwRst,
  input  regStrobe_t    strobe,
  input  logic [AW-1:0] rdSel,
  input  logic [DW-1:0] pwrCtl,
  input  logic          rtcAlarm,
  input  logic [EW-1:0] wakeEvt,
  output logic [DW-1:0] rdData,
  output logic          irq
);
  logic [DW-1:0] maskReg, pwrPrev, chgFlag, chgEn, chgSeen;
  logic [DW-1:0] hostStat, wakeStat, evtVec;
  logic [DW-1:0] chgClr, hostClr, wakeClr;
  logic          irqNext;

  // bit 0 (S0) is enabled by any of the S1..S5 enables
  assign chgEn   = {maskReg[DW-1:1], |maskReg[5:1]};
  assign chgSeen = pwrCtl ^ pwrPrev;

  always_comb begin
    evtVec           = '0;
    evtVec[POS_RI1]  = wakeEvt[0];
    evtVec[POS_RI2]  = wakeEvt[1];
    evtVec[POS_RING] = wakeEvt[2];
    evtVec[POS_MOD]  = wakeEvt[3];
    evtVec[POS_SW]   = wakeEvt[4];
  end

  assign chgClr  = strobe.clrChg  ? strobe.data : '0;
  assign hostClr = strobe.clrHost ? strobe.data : '0;
  assign wakeClr = strobe.clrWake ? strobe.data : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      pwrPrev <= '0;
    end else begin
      pwrPrev <= pwrCtl;
      if (strobe.wrMask) maskReg <= strobe.data;
    end
  end

  // one latched change flag per watched bit; a new change wins over a clear
  for (genvar i = 0; i < DW; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chgFlag[i] <= 1'b0;
      else       chgFlag[i] <= (chgFlag[i] & ~chgClr[i]) | (chgSeen[i] & chgEn[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostStat <= '0;
      wakeStat <= '0;
    end else begin
      if (hostSwRst) hostStat <= '0;
      else           hostStat <= (hostStat & ~hostClr) | evtVec;
      wakeStat <= (wakeStat & ~wakeClr) | evtVec;
    end
  end

  assign irqNext = |(chgFlag & chgEn) | (rtcAlarm & maskReg[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= irqNext;
  end

  always_comb begin
    case (rdSel)
      ADDR_MASK: rdData = maskReg;
      ADDR_CHG:  rdData = chgFlag;
      ADDR_HOST: rdData = hostStat;
      default:   rdData = wakeStat;
    endcase
  end

  // R5: an S0 change is caught whenever some S1..S5 enable is on
  a_r5_s0_implied: assert property (@(posedge clk) disable iff (!rstN)
    (chgSeen[0] && (|maskReg[5:1])) |=> chgFlag[0]);

  // R6: a disabled supply-off bit never sets its flag
  a_r6_masked_no_latch: assert property (@(posedge clk) disable iff (!rstN)
    (!chgFlag[7] && !maskReg[7]) |=> !chgFlag[7]);

  // R9: a host status bit holds unless cleared by a 1 or by the software reset
  a_r9_w0_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (hostStat[POS_RI2] && !(strobe.clrHost && strobe.data[POS_RI2]) && !hostSwRst)
    |=> hostStat[POS_RI2]);

  // R12: an event at the same edge as a clear leaves the bit set
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wakeEvt[0] && strobe.clrWake && strobe.data[POS_RI1]) |=> wakeStat[POS_RI1]);

  // R13: with an all-zero mask nothing interrupts
  a_r13_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskReg) == '0) |-> !irq);

  // R11: the software reset leaves the wake copy unchanged when nothing else touches it
  a_r11_wake_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (hostSwRst && !strobe.clrWake && (wakeEvt == '0)) |=> $stable(wakeStat));
endmodule

// File: rtl/pwr_event_irq.sv
module pwr_event_irq
  import pwr_event_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSwRst,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] pwrCtl,
  input  logic              rtcAlarm,
  input  logic [EVT_W-1:0]  wakeEvt,
  output logic              irq
);
  regStrobe_t        strobe;
  logic [ADDR_W-1:0] rdSel;

  pwr_event_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe),
    .rdSel    (rdSel)
  );

  pwr_event_dp #(.AW(ADDR_W), .DW(DATA_W), .EW(EVT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostSwRst (hostSwRst),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .pwrCtl    (pwrCtl),
    .rtcAlarm  (rtcAlarm),
    .wakeEvt   (wakeEvt),
    .rdData    (busRdata),
    .irq       (irq)
  );
endmodule

// File: tb/pwr_event_irq_test.sv
module pwr_event_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostSwRst = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] pwrCtl = '0;
  logic       rtcAlarm = 1'b0;
  logic [4:0] wakeEvt = '0;
  logic       irq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_event_irq uut (
    .clk(clk), .rstN(rstN), .hostSwRst(hostSwRst), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pwrCtl(pwrCtl), .rtcAlarm(rtcAlarm), .wakeEvt(wakeEvt), .irq(irq)
  );

  // fields: req, we, addr, wdata, pwr, alarm, evt, chkAddr, expRd, expIrq
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd2, 1'b1,2'd0,8'h02, 8'h00,1'b0,5'h00, 2'd0,8'h02,1'b0},  // R2 enable S1
    {4'd4, 1'b0,2'd0,8'h00, 8'h02,1'b0,5'h00, 2'd1,8'h02,1'b0},  // R4 S1 rise
    {4'd4, 1'b0,2'd0,8'h00, 8'h02,1'b0,5'h00, 2'd1,8'h02,1'b1},  // R4 irq next edge
    {4'd7, 1'b1,2'd1,8'h00, 8'h02,1'b0,5'h00, 2'd1,8'h02,1'b1},  // R7 write 0 no effect
    {4'd7, 1'b1,2'd1,8'h02, 8'h02,1'b0,5'h00, 2'd1,8'h00,1'b1},  // R7 clear
    {4'd7, 1'b0,2'd0,8'h00, 8'h02,1'b0,5'h00, 2'd1,8'h00,1'b0},  // R7 irq falls
    {4'd4, 1'b0,2'd0,8'h00, 8'h00,1'b0,5'h00, 2'd1,8'h02,1'b0},  // R4 S1 fall
    {4'd4, 1'b0,2'd0,8'h00, 8'h00,1'b0,5'h00, 2'd1,8'h02,1'b1},  // R4
    {4'd13,1'b1,2'd0,8'h00, 8'h00,1'b0,5'h00, 2'd0,8'h00,1'b1},  // R13 mask off
    {4'd13,1'b0,2'd0,8'h00, 8'h00,1'b0,5'h00, 2'd1,8'h02,1'b0},  // R13 flag kept, irq low
    {4'd5, 1'b0,2'd0,8'h00, 8'h01,1'b0,5'h00, 2'd1,8'h02,1'b0},  // R5/R6 S0 not enabled
    {4'd7, 1'b1,2'd1,8'hFF, 8'h01,1'b0,5'h00, 2'd1,8'h00,1'b0},  // R7 clear all
    {4'd2, 1'b1,2'd0,8'h20, 8'h01,1'b0,5'h00, 2'd0,8'h20,1'b0},  // R2 enable S5
    {4'd5, 1'b0,2'd0,8'h00, 8'h00,1'b0,5'h00, 2'd1,8'h01,1'b0},  // R5 S0 implied
    {4'd6, 1'b0,2'd0,8'h00, 8'h80,1'b0,5'h00, 2'd1,8'h01,1'b1},  // R6 supply-off masked
    {4'd7, 1'b1,2'd1,8'h01, 8'h80,1'b0,5'h00, 2'd1,8'h00,1'b1},  // R7
    {4'd3, 1'b1,2'd0,8'h01, 8'h80,1'b1,5'h00, 2'd0,8'h01,1'b0},  // R3 alarm enable
    {4'd3, 1'b0,2'd0,8'h00, 8'h80,1'b1,5'h00, 2'd1,8'h00,1'b1},  // R3 level high
    {4'd3, 1'b0,2'd0,8'h00, 8'h80,1'b0,5'h00, 2'd1,8'h00,1'b0},  // R3 not latched
    {4'd8, 1'b0,2'd0,8'h00, 8'h80,1'b0,5'h01, 2'd2,8'h01,1'b0},  // R8 RI1
    {4'd10,1'b0,2'd0,8'h00, 8'h80,1'b0,5'h04, 2'd3,8'h09,1'b0},  // R10 RING copy
    {4'd8, 1'b0,2'd0,8'h00, 8'h80,1'b0,5'h18, 2'd2,8'hC9,1'b0},  // R8 module+sw
    {4'd9, 1'b1,2'd2,8'h01, 8'h80,1'b0,5'h00, 2'd2,8'hC8,1'b0},  // R9 clear RI1
    {4'd10,1'b0,2'd0,8'h00, 8'h80,1'b0,5'h00, 2'd3,8'hC9,1'b0},  // R10 copy untouched
    {4'd10,1'b1,2'd3,8'hC0, 8'h80,1'b0,5'h00, 2'd3,8'h09,1'b0},  // R10 clear copy
    {4'd10,1'b0,2'd0,8'h00, 8'h80,1'b0,5'h00, 2'd2,8'hC8,1'b0},  // R10 host untouched
    {4'd12,1'b1,2'd2,8'h40, 8'h80,1'b0,5'h08, 2'd2,8'hC8,1'b0},  // R12 event beats clear
    {4'd8, 1'b0,2'd0,8'h00, 8'h80,1'b0,5'h02, 2'd2,8'hCA,1'b0},  // R8 RI2
    {4'd10,1'b0,2'd0,8'h00, 8'h80,1'b0,5'h00, 2'd3,8'h4B,1'b0},  // R10
    {4'd2, 1'b1,2'd0,8'hFF, 8'h80,1'b0,5'h00, 2'd0,8'hFF,1'b0},  // R2 all enables
    {4'd4, 1'b0,2'd0,8'h00, 8'h40,1'b0,5'h00, 2'd1,8'hC0,1'b0},  // R4 mode rise, supply fall
    {4'd4, 1'b0,2'd0,8'h00, 8'h40,1'b0,5'h00, 2'd1,8'hC0,1'b1}   // R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [7:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
    wakeEvt = '0;
    hostSwRst = 1'b0;
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R1 reset state
    for (int a = 0; a < 4; a++) readCheck("R1 reset reg", 2'(a), 8'h00);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      string tag;
      v = VEC[i];
      busWe    = v[35];
      busAddr  = v[34:33];
      busWdata = v[32:25];
      pwrCtl   = v[24:17];
      rtcAlarm = v[16];
      wakeEvt  = v[15:11];
      tick();
      tag = $sformatf("R%0d vector %0d", v[39:36], i);
      readCheck(tag, v[10:9], v[8:1]);
      check({tag, " irq"}, {7'd0, irq}, {7'd0, v[0]});
    end

    // R11 software reset clears host status only
    hostSwRst = 1'b1;
    tick();
    readCheck("R11 host cleared", 2'd2, 8'h00);
    readCheck("R11 wake kept", 2'd3, 8'h4B);

    // R8 all events: reserved bits stay zero
    wakeEvt = 5'h1F;
    tick();
    readCheck("R8 reserved zero", 2'd2, 8'hCB);

    // R12 change at same edge as its clear keeps the flag
    pwrCtl   = 8'h00;
    busWe    = 1'b1;
    busAddr  = 2'd1;
    busWdata = 8'h40;
    tick();
    readCheck("R12 change beats clear", 2'd1, 8'hC0);
    check("R13 irq pending", {7'd0, irq}, 8'h01);

    // R1 asynchronous reset returns everything to zero
    rstN = 1'b0;
    #1;
    for (int a = 0; a < 4; a++) readCheck("R1 async reset reg", 2'(a), 8'h00);
    check("R1 async reset irq", {7'd0, irq}, 8'h00);

    done = 1'b1;
    finishRun();
  end
endmodule